// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block takes two 32-bit binary floating-point words and returns their product in the same format. The layout of each word is fixed: the sign is bit 31, the exponent field is bits 30:23 and is biased by 127, and the fraction is bits 22:0. Every non-zero finite operand carries an implicit leading one. Each operand is split into its fields and sorted into one of four classes: zero (exponent field 0, so subnormal inputs are flushed), infinity, NaN, or an ordinary number. For two ordinary numbers the block adds the biased exponents and removes the bias. It multiplies the two 24-bit significands and applies at most one right-shift normalisation. It then rounds to nearest with ties to even, using a guard bit, a round bit and a sticky bit. If the rounding increment carries out of the significand, the result is renormalised.

The datapath is a fixed-latency pipeline with a valid bit beside it. When the parameter `REG_MID` is 1, a register stage sits between the significand multiply and the normalise/round logic, and a result appears two cycles after its operands are accepted. When `REG_MID` is 0 the latency is one cycle. Three flags accompany the result: overflow, underflow and invalid.

Top module: `sp_fmul`

## Requirements
- R1: For two operands whose exponent fields are both between 1 and 254, the result sign (bit 31) is the XOR of the operand signs. The result exponent is the sum of the two exponent fields minus 127, adjusted by normalisation and rounding. For example, 0xBF400000 times 0x3F800000 gives 0xBF400000.
- R2: If the exact significand product is 2 or more, it is shifted right by one place and the exponent is incremented by one. Otherwise no shift is applied.
- R3: The 23 kept fraction bits are rounded to nearest. The guard bit is the first discarded bit, the round bit is the next, and the sticky bit is the OR of all the rest. An exact tie rounds to the value whose fraction LSB is 0.
- R4: If rounding carries out of the 24-bit significand, the fraction becomes zero and the exponent is incremented once more.
- R5: If the final exponent is 255 or more, the result is a signed infinity (exponent all ones, fraction zero) and the overflow flag is set.
- R6: If the final exponent is 0 or less, the result is a signed zero (bits 30:0 all zero) and the underflow flag is set.
- R7: An operand whose exponent field is 0 counts as zero, whatever its fraction. Zero times a finite value gives a zero with sign equal to the XOR of the operand signs, and no flag is set.
- R8: If either operand is a NaN (exponent 255, fraction non-zero), the result is 0x7FC00000 and no flag is set. This rule takes precedence over every other rule.
- R9: Infinity (exponent 255, fraction zero) times zero, in either operand order, gives 0x7FC00000 and sets the invalid flag.
- R10: Infinity times a non-zero finite value or times infinity gives an infinity with sign equal to the XOR of the operand signs, and no flag is set.
- R11: `out_valid` is low after reset. It goes high exactly 1 + `REG_MID` cycles after each cycle in which `in_valid` is high, and results leave in the order their operands arrived.
- R12: At most one of the three flags is set for any valid result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Operands on op_a and op_b are accepted this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | result and flags hold a new product |
| result | output | 32 | Product word |
| flag_ovf | output | 1 | Result exponent was too large; result is infinity |
| flag_unf | output | 1 | Result exponent was too small; result is zero |
| flag_inv | output | 1 | Infinity was multiplied by zero |

## Verification
Some properties are checked by assertions on every cycle. The valid bit must track the input valid at the fixed latency. Each flag must come with its prescribed encoding: infinity with overflow, zero with underflow, the canonical quiet NaN with invalid. No output may carry a NaN other than the canonical one, or a subnormal. At most one flag may be set. Whether the fraction bits are rounded correctly, whether ties go to even, and whether a rounding carry renormalises can only be shown by the bench. It compares every result against an integer model of the exact product, using directed tie, carry and boundary cases and random operands.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  localparam int EXP_W   = 8;
  localparam int MAN_W   = 23;
  localparam int WORD_W  = 1 + EXP_W + MAN_W;
  localparam int SIG_W   = MAN_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int XW      = EXP_W + 2;            // signed exponent headroom
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  typedef enum logic [2:0] {
    CLS_NUM,
    CLS_ZERO,
    CLS_INF,
    CLS_NAN,
    CLS_INVALID
  } cls_e;

  typedef struct packed {
    logic            sign;
    cls_e            cls;
    logic [XW-1:0]   exp_sum;  // two's complement, bias already removed
    logic [PROD_W-1:0] prod;
  } mid_t;

  function automatic logic [WORD_W-1:0] canon_nan();
    return {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack
  import fmul_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              sign,
  output logic [EXP_W-1:0]  exp,
  output logic [SIG_W-1:0]  sig,
  output logic              is_zero,
  output logic              is_inf,
  output logic              is_nan
);
  logic [MAN_W-1:0] frac;

  assign sign    = word[WORD_W-1];
  assign exp     = word[WORD_W-2 -: EXP_W];
  assign frac    = word[MAN_W-1:0];
  assign sig     = {1'b1, frac};
  // subnormal encodings are flushed: any zero exponent counts as zero
  assign is_zero = (exp == '0);
  assign is_inf  = (&exp) && (frac == '0);
  assign is_nan  = (&exp) && (frac != '0);
endmodule

// File: rtl/fmul_round.sv
module fmul_round
  import fmul_pkg::*;
(
  input  mid_t              mid,
  output logic [WORD_W-1:0] res,
  output logic              ovf,
  output logic              unf,
  output logic              inv
);
  logic              hi;
  logic [PROD_W-2:0] norm;
  logic [MAN_W-1:0]  man;
  logic              g_bit, r_bit, s_bit, inc;
  logic [MAN_W:0]    rnd;
  logic [XW-1:0]     exp_f;
  logic              ovf_c, unf_c;

  always_comb begin
    hi    = mid.prod[PROD_W-1];
    // single-step normalisation: product lies in [1,4)
    norm  = hi ? mid.prod[PROD_W-2:0] : {mid.prod[PROD_W-3:0], 1'b0};
    man   = norm[PROD_W-2 -: MAN_W];
    g_bit = norm[PROD_W-2-MAN_W];
    r_bit = norm[PROD_W-3-MAN_W];
    s_bit = |norm[PROD_W-4-MAN_W:0];
    inc   = g_bit & (r_bit | s_bit | man[0]);
    rnd   = {1'b0, man} + (MAN_W+1)'(inc);
    exp_f = mid.exp_sum + XW'(hi) + XW'(rnd[MAN_W]);
    ovf_c = !exp_f[XW-1] && (exp_f >= XW'(EXP_MAX));
    unf_c = exp_f[XW-1] || (exp_f == '0);

    res = '0;
    ovf = 1'b0;
    unf = 1'b0;
    inv = 1'b0;
    unique case (mid.cls)
      CLS_NAN:     res = canon_nan();
      CLS_INVALID: begin
        res = canon_nan();
        inv = 1'b1;
      end
      CLS_INF:     res = {mid.sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      CLS_ZERO:    res = {mid.sign, {(WORD_W-1){1'b0}}};
      default: begin
        if (ovf_c) begin
          res = {mid.sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
          ovf = 1'b1;
        end else if (unf_c) begin
          res = {mid.sign, {(WORD_W-1){1'b0}}};
          unf = 1'b1;
        end else begin
          res = {mid.sign, exp_f[EXP_W-1:0], rnd[MAN_W-1:0]};
        end
      end
    endcase
  end
endmodule

// File: rtl/sp_fmul.sv
module sp_fmul
  import fmul_pkg::*;
#(
  parameter bit REG_MID = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic              flag_ovf,
  output logic              flag_unf,
  output logic              flag_inv
);
  logic [1:0][WORD_W-1:0] ops;
  logic [1:0]             u_sign, u_zero, u_inf, u_nan;
  logic [1:0][EXP_W-1:0]  u_exp;
  logic [1:0][SIG_W-1:0]  u_sig;

  assign ops = {op_b, op_a};

  for (genvar gi = 0; gi < 2; gi++) begin : g_unp
    fmul_unpack u_unp (
      .word    (ops[gi]),
      .sign    (u_sign[gi]),
      .exp     (u_exp[gi]),
      .sig     (u_sig[gi]),
      .is_zero (u_zero[gi]),
      .is_inf  (u_inf[gi]),
      .is_nan  (u_nan[gi])
    );
  end

  // classify and multiply
  mid_t mid_d;
  always_comb begin
    mid_d.sign = ^u_sign;
    if (|u_nan)
      mid_d.cls = CLS_NAN;
    else if ((u_inf[0] & u_zero[1]) | (u_inf[1] & u_zero[0]))
      mid_d.cls = CLS_INVALID;
    else if (|u_inf)
      mid_d.cls = CLS_INF;
    else if (|u_zero)
      mid_d.cls = CLS_ZERO;
    else
      mid_d.cls = CLS_NUM;
    mid_d.exp_sum = XW'(u_exp[0]) + XW'(u_exp[1]) - XW'(BIAS);
    mid_d.prod    = PROD_W'(u_sig[0]) * PROD_W'(u_sig[1]);
  end

  // optional register between multiply and rounding
  mid_t mid_q;
  logic mid_vld;

  if (REG_MID) begin : g_mid_reg
    logic mid_vld_nxt;
    mid_t mid_nxt;
    always_comb begin
      mid_vld_nxt = in_valid;
      mid_nxt     = in_valid ? mid_d : mid_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mid_vld <= 1'b0;
      else        mid_vld <= mid_vld_nxt;
    end
    always_ff @(posedge clk) begin
      if (in_valid) mid_q <= mid_nxt;
    end
  end else begin : g_mid_wire
    assign mid_q   = mid_d;
    assign mid_vld = in_valid;
  end

  // normalise, round, pack
  logic [WORD_W-1:0] res_d;
  logic              ovf_d, unf_d, inv_d;

  fmul_round u_rnd (
    .mid (mid_q),
    .res (res_d),
    .ovf (ovf_d),
    .unf (unf_d),
    .inv (inv_d)
  );

  // output register
  logic              out_vld_nxt;
  logic [WORD_W-1:0] res_nxt;
  logic [2:0]        flg_nxt;

  always_comb begin
    out_vld_nxt = mid_vld;
    res_nxt     = mid_vld ? res_d : result;
    flg_nxt     = mid_vld ? {ovf_d, unf_d, inv_d} : {flag_ovf, flag_unf, flag_inv};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= out_vld_nxt;
  end

  always_ff @(posedge clk) begin
    if (mid_vld) begin
      result                         <= res_nxt;
      {flag_ovf, flag_unf, flag_inv} <= flg_nxt;
    end
  end
endmodule

// File: rtl/fmul_chk.sv
module fmul_chk
  import fmul_pkg::*;
#(
  parameter int LAT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic [WORD_W-1:0] result,
  input logic              flag_ovf,
  input logic              flag_unf,
  input logic              flag_inv
);
  logic [EXP_W-1:0] r_exp;
  logic [MAN_W-1:0] r_frac;
  assign r_exp  = result[WORD_W-2 -: EXP_W];
  assign r_frac = result[MAN_W-1:0];

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, LAT)); // R11

  AST_INV_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_inv) |-> (result == canon_nan())); // R9

  AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_ovf) |-> ((&r_exp) && (r_frac == '0))); // R5

  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_unf) |-> (result[WORD_W-2:0] == '0)); // R6

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({flag_ovf, flag_unf, flag_inv}) <= 1)); // R12

  AST_NO_SUBNORM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (r_exp == '0)) |-> (r_frac == '0)); // R7

  AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&r_exp) && (r_frac != '0)) |-> (result == canon_nan())); // R8
endmodule

bind sp_fmul fmul_chk #(.LAT(REG_MID ? 2 : 1)) u_fmul_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .result    (result),
  .flag_ovf  (flag_ovf),
  .flag_unf  (flag_unf),
  .flag_inv  (flag_inv)
);

// File: tb/sp_fmul_bench.sv
module sp_fmul_bench;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_ovf, flag_unf, flag_inv;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  logic [34:0] exp_q[$];
  string       tag_q[$];
  int          iss_q[$];

  always #2 clk = ~clk;

  sp_fmul u_sp_fmul (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result),
    .flag_ovf  (flag_ovf),
    .flag_unf  (flag_unf),
    .flag_inv  (flag_inv)
  );

  // Expected {result, ovf, unf, inv}, from exact integer arithmetic
  function automatic logic [34:0] model(input logic [31:0] a, input logic [31:0] b);
    logic s;
    int ea, eb, e, sh;
    logic [22:0] fa, fb;
    logic [63:0] p, q, rem, half;
    bit a_nan, b_nan, a_inf, b_inf, a_z, b_z;
    s  = a[31] ^ b[31];
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    fa = a[22:0];
    fb = b[22:0];
    a_nan = (ea == 255) && (fa != 0);
    b_nan = (eb == 255) && (fb != 0);
    a_inf = (ea == 255) && (fa == 0);
    b_inf = (eb == 255) && (fb == 0);
    a_z   = (ea == 0);
    b_z   = (eb == 0);
    if (a_nan || b_nan) return {32'h7FC00000, 3'b000};
    if ((a_inf && b_z) || (b_inf && a_z)) return {32'h7FC00000, 3'b001};
    if (a_inf || b_inf) return {s, 8'hFF, 23'd0, 3'b000};
    if (a_z || b_z) return {s, 31'd0, 3'b000};
    p  = {40'd0, 1'b1, fa} * {40'd0, 1'b1, fb};
    e  = ea + eb - 127;
    sh = 23;
    if (p >= (64'd1 << 47)) begin
      sh = 24;
      e  = e + 1;
    end
    q    = p >> sh;
    rem  = p & ((64'd1 << sh) - 64'd1);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && q[0])) q = q + 64'd1;
    if (q == (64'd1 << 24)) begin
      q = q >> 1;
      e = e + 1;
    end
    if (e >= 255) return {s, 8'hFF, 23'd0, 3'b100};
    if (e <= 0)   return {s, 31'd0, 3'b010};
    return {s, e[7:0], q[22:0], 3'b000};
  endfunction

  function automatic string auto_tag(input logic [34:0] x);
    if (x[2]) return "R5";
    if (x[1]) return "R6";
    if (x[0]) return "R9";
    if (x[33:26] == 8'hFF && x[25:3] != 0) return "R8";
    if (x[33:26] == 8'hFF) return "R10";
    if (x[33:3] == 0) return "R7";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  task automatic cycle(input bit v, input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    cyc++;
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R11: got unexpected out_valid expected none");
      end else begin
        logic [34:0] ev;
        string t;
        int iss;
        ev  = exp_q.pop_front();
        t   = tag_q.pop_front();
        iss = iss_q.pop_front();
        check(t, {result, flag_ovf, flag_unf, flag_inv}, ev);
        check("R11", 35'(cyc - iss), 35'(LAT));
        check("R12", 35'($countones({flag_ovf, flag_unf, flag_inv}) > 1), 35'd0);
      end
    end
    in_valid = v;
    op_a     = a;
    op_b     = b;
    if (v) begin
      logic [34:0] m;
      m = model(a, b);
      exp_q.push_back(m);
      tag_q.push_back(tag == "" ? auto_tag(m) : tag);
      iss_q.push_back(cyc);
    end
  endtask

  function automatic logic [31:0] rand_op();
    logic [7:0]  e;
    logic [22:0] f;
    int sel;
    sel = int'($urandom % 16);
    f   = 23'($urandom);
    case (sel)
      0:       e = 8'd0;
      1:       begin e = 8'hFF; f = 23'd0; end
      2:       begin e = 8'hFF; if (f == 0) f = 23'd1; end
      3, 4, 5: e = 8'($urandom_range(1, 254));
      default: e = 8'($urandom_range(64, 190));
    endcase
    return {1'($urandom), e, f};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    op_a     = '0;
    op_b     = '0;
    repeat (3) @(negedge clk);
    check("R11", {34'd0, out_valid}, 35'd0);   // reset state
    rst_n = 1'b1;

    cycle(1, 32'hBF400000, 32'h3F800000, "R1");  // -0.75 * 1
    cycle(1, 32'h40000000, 32'h40400000, "R1");  // 2 * 3
    cycle(1, 32'h3FC00000, 32'h3FC00000, "R2");  // 1.5 * 1.5, product >= 2
    cycle(1, 32'h3F800001, 32'h3FC00000, "R3");  // tie, odd LSB rounds up
    cycle(1, 32'h3F800003, 32'h3FC00000, "R3");  // tie, even LSB stays
    cycle(0, 32'h0, 32'h0, "");
    cycle(1, 32'h3FFFFFFE, 32'h3F800001, "R4");  // rounding carry to 2.0
    cycle(1, 32'h7F000000, 32'h40000000, "R5");
    cycle(1, 32'hFF7FFFFF, 32'h7F7FFFFF, "R5");
    cycle(1, 32'h7F7FFFFF, 32'h3F800001, "R5");
    cycle(1, 32'h00800000, 32'h3F000000, "R6");
    cycle(1, 32'h80800000, 32'h00800000, "R6");
    cycle(1, 32'h00000001, 32'h3F800000, "R7");  // subnormal flushed
    cycle(1, 32'h80400000, 32'h3F800000, "R7");
    cycle(1, 32'h00000000, 32'hC0000000, "R7");
    cycle(1, 32'h7FC00001, 32'h3F800000, "R8");
    cycle(1, 32'h7F800001, 32'h00000000, "R8");  // NaN wins over invalid
    cycle(1, 32'hFFFFFFFF, 32'h7F800000, "R8");
    cycle(1, 32'h7F800000, 32'h00000000, "R9");
    cycle(1, 32'h80000000, 32'hFF800000, "R9");
    cycle(1, 32'h7F800000, 32'hC0000000, "R10");
    cycle(1, 32'hFF800000, 32'hFF800000, "R10");

    for (int i = 0; i < 4000; i++) begin
      bit v;
      v = ($urandom % 4) != 0;
      cycle(v, rand_op(), rand_op(), "");
    end
    repeat (LAT + 3) cycle(0, 32'h0, 32'h0, "");
    check("R11", 35'(exp_q.size()), 35'd0);        // all results delivered

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule